// File: doc/BRIEF.md
# EEPROM Byte-Access Command Controller

This block gives a host single-byte read and write access to an 8 KiB byte-addressed EEPROM through two 32-bit registers. One register holds the command word, which combines the target byte address, an opcode, a start/busy flag and a timeout flag. The other holds the data byte. To write, the host first loads the data byte and then writes the command word with the write opcode and the start bit set. To read, it writes the command word with a read opcode and the start bit. In both cases the host polls until busy clears and then checks the timeout flag.

The serial device itself sits behind a request/acknowledge back-end port. While a command is in flight the controller holds a request, together with the address, the direction and the write byte. The back end answers with a one-cycle acknowledge, which carries the read byte when the command is a read. A cycle counter bounds the wait. If no acknowledge arrives within `TMO_LIMIT` cycles, the controller abandons the command and sets the timeout flag.

A command word that carries only the start bit is a read of byte 0. It serves as a presence probe: the timeout flag after completion shows whether a device answered.

Top module: `eeprom_cmd_ctrl`

## Requirements
- R1: After reset both registers read as zero, busy and timeout are clear, and `be_req` is low.
- R2: Register decoding works as follows. Offset 0 is the command word and offset 4 is the data register. In the command word, bit 31 is busy, bits 29:28 are the opcode (2'b11 means write, any other value means read), bit 17 is timeout and bits 12:0 are the byte address. All other command bits read as zero. The data register returns its byte in bits 7:0 with zeros above it. Any other offset reads as zero.
- R3: A command write with bit 31 set while idle makes busy readable and raises `be_req` on the next cycle. That request carries the stored address on `be_addr` and asserts `be_write` only for the write opcode.
- R4: An acknowledge received while requesting clears busy and `be_req` at that clock edge. For a read, the same edge latches `be_rdata` into the data register.
- R5: During a write command, `be_wdata` presents the data byte loaded before the start, and completing the write leaves the data register unchanged.
- R6: If no acknowledge arrives during the `TMO_LIMIT` cycles of a request, busy clears, `be_req` drops and the timeout bit sets exactly `TMO_LIMIT` cycles after the start. An acknowledge in the last of those cycles still completes the command normally.
- R7: Writing the command word with bit 17 set clears the timeout flag. Starting a new command also clears it.
- R8: Writes to either register while busy have no effect on the address, opcode or data.
- R9: A command word containing only the start bit reads byte 0. It completes with timeout clear when the device answers and with timeout set when the device does not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | OFS_W | Host register byte offset |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Read data for the register at `reg_addr` (combinational) |
| be_req | output | 1 | Back-end access request, held until acknowledge or timeout |
| be_write | output | 1 | Request is a write |
| be_addr | output | 13 | Byte address of the request |
| be_wdata | output | 8 | Byte to write |
| be_ack | input | 1 | One-cycle acknowledge from the back end |
| be_rdata | input | 8 | Byte returned with the acknowledge of a read |

## Verification
Some properties are checked on every cycle. An acknowledge must end the request on the next edge, and a read acknowledge must land its byte in the data register. The timeout flag may rise only after an unacknowledged request cycle, and a request may never last beyond `TMO_LIMIT` cycles. The request address must stay stable while the request is up, and an idle start must raise the request with the timeout flag clear. The bench's scenarios cover the rest: read-back of bytes written at both ends of the address range, commands and data writes dropped while busy, the exact length of a timeout, acknowledges on the last allowed cycle and one cycle too late, flag clearing, and probes with and without a device present.

// File: rtl/eecmd_pkg.sv
`timescale 1ns/1ps
package eecmd_pkg;
    localparam int EE_ADDR_W = 13;
    localparam int EE_DATA_W = 8;
    localparam int REG_W     = 32;
    localparam int BUSY_POS  = 31;
    localparam int OP_HI_POS = 29;
    localparam int OP_LO_POS = 28;
    localparam int TMO_POS   = 17;
    localparam int CMD_OFS   = 0;
    localparam int DAT_OFS   = 4;
    localparam logic [1:0] OP_WRITE = 2'b11;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } ee_state_e;

    typedef struct packed {
        ee_state_e             state;
        logic                  tmo;
        logic [1:0]            op;
        logic [EE_ADDR_W-1:0]  addr;
        logic [EE_DATA_W-1:0]  data;
    } ee_ctl_s;
endpackage

// File: rtl/eecmd_timer.sv
`timescale 1ns/1ps
module eecmd_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d   = run ? cnt_q + CW'(1) : '0;
        expired = run && (cnt_q == CW'(LIMIT - 1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/eecmd_core.sv
`timescale 1ns/1ps
module eecmd_core
    import eecmd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_wr,
    input  logic                 dat_wr,
    input  logic [EE_ADDR_W-1:0] wr_addr,
    input  logic [1:0]           wr_op,
    input  logic                 wr_tmo_clr,
    input  logic                 wr_start,
    input  logic [EE_DATA_W-1:0] wr_byte,
    input  logic                 be_ack,
    input  logic [EE_DATA_W-1:0] be_rdata,
    input  logic                 expired,
    output ee_ctl_s              ctl_q
);
    ee_ctl_s ctl_d;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (cmd_wr) begin
                    ctl_d.addr = wr_addr;
                    ctl_d.op   = wr_op;
                    if (wr_tmo_clr) ctl_d.tmo = 1'b0;
                    if (wr_start) begin
                        ctl_d.state = ST_WAIT;
                        ctl_d.tmo   = 1'b0;
                    end
                end
                if (dat_wr) ctl_d.data = wr_byte;
            end
            ST_WAIT: begin
                if (be_ack) begin
                    ctl_d.state = ST_IDLE;
                    if (ctl_q.op != OP_WRITE) ctl_d.data = be_rdata;
                end else if (expired) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.tmo   = 1'b1;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end
endmodule

// File: rtl/eecmd_rdmux.sv
`timescale 1ns/1ps
module eecmd_rdmux
    import eecmd_pkg::*;
#(
    parameter int OFS_W = 3
) (
    input  ee_ctl_s          ctl,
    input  logic [OFS_W-1:0] ofs,
    output logic [REG_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (ofs == OFS_W'(CMD_OFS)) begin
            rdata[BUSY_POS]              = (ctl.state == ST_WAIT);
            rdata[OP_HI_POS:OP_LO_POS]   = ctl.op;
            rdata[TMO_POS]               = ctl.tmo;
            rdata[EE_ADDR_W-1:0]         = ctl.addr;
        end else if (ofs == OFS_W'(DAT_OFS)) begin
            rdata[EE_DATA_W-1:0]         = ctl.data;
        end
    end
endmodule

// File: rtl/eeprom_cmd_ctrl.sv
`timescale 1ns/1ps
module eeprom_cmd_ctrl
    import eecmd_pkg::*;
#(
    parameter int TMO_LIMIT = 64,
    parameter int OFS_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [OFS_W-1:0]     reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    output logic                 be_req,
    output logic                 be_write,
    output logic [EE_ADDR_W-1:0] be_addr,
    output logic [EE_DATA_W-1:0] be_wdata,
    input  logic                 be_ack,
    input  logic [EE_DATA_W-1:0] be_rdata
);
    ee_ctl_s              ctl_q;
    logic                 expired;
    logic                 cmd_wr, dat_wr;
    logic                 tmo_q;
    logic [EE_DATA_W-1:0] data_q;

    assign cmd_wr = reg_wr && (reg_addr == OFS_W'(CMD_OFS));
    assign dat_wr = reg_wr && (reg_addr == OFS_W'(DAT_OFS));

    eecmd_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (cmd_wr),
        .dat_wr     (dat_wr),
        .wr_addr    (reg_wdata[EE_ADDR_W-1:0]),
        .wr_op      (reg_wdata[OP_HI_POS:OP_LO_POS]),
        .wr_tmo_clr (reg_wdata[TMO_POS]),
        .wr_start   (reg_wdata[BUSY_POS]),
        .wr_byte    (reg_wdata[EE_DATA_W-1:0]),
        .be_ack     (be_ack),
        .be_rdata   (be_rdata),
        .expired    (expired),
        .ctl_q      (ctl_q)
    );

    eecmd_timer #(.LIMIT(TMO_LIMIT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (be_req),
        .expired (expired)
    );

    eecmd_rdmux #(.OFS_W(OFS_W)) u_rdmux (
        .ctl   (ctl_q),
        .ofs   (reg_addr),
        .rdata (reg_rdata)
    );

    assign be_req   = (ctl_q.state == ST_WAIT);
    assign be_write = (ctl_q.op == OP_WRITE);
    assign be_addr  = ctl_q.addr;
    assign be_wdata = ctl_q.data;
    assign tmo_q    = ctl_q.tmo;
    assign data_q   = ctl_q.data;
endmodule

// File: rtl/eecmd_chk.sv
`timescale 1ns/1ps
module eecmd_chk
    import eecmd_pkg::*;
#(
    parameter int TMO_LIMIT = 64,
    parameter int OFS_W     = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_wr,
    input logic [OFS_W-1:0]     reg_addr,
    input logic [REG_W-1:0]     reg_wdata,
    input logic                 be_req,
    input logic                 be_write,
    input logic [EE_ADDR_W-1:0] be_addr,
    input logic                 be_ack,
    input logic [EE_DATA_W-1:0] be_rdata,
    input logic                 tmo_q,
    input logic [EE_DATA_W-1:0] data_q
);
    int run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      run_q <= 0;
        else if (be_req) run_q <= run_q + 1;
        else             run_q <= 0;
    end

    AST_ACK_ENDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (be_req && be_ack) |=> !be_req); // R4

    AST_READ_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (be_req && be_ack && !be_write) |=> (data_q == $past(be_rdata))); // R4

    AST_TMO_AFTER_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_q) |-> $past(be_req && !be_ack)); // R6

    AST_REQ_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        be_req |-> (run_q < TMO_LIMIT)); // R6

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (be_req && $past(be_req)) |-> $stable(be_addr)); // R8

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!be_req && reg_wr && reg_addr == OFS_W'(CMD_OFS) && reg_wdata[BUSY_POS])
        |=> (be_req && !tmo_q)); // R3 R7

    AST_WDATA_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> !$isunknown(reg_wdata)); // R2
endmodule

bind eeprom_cmd_ctrl eecmd_chk #(.TMO_LIMIT(TMO_LIMIT), .OFS_W(OFS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .be_req    (be_req),
    .be_write  (be_write),
    .be_addr   (be_addr),
    .be_ack    (be_ack),
    .be_rdata  (be_rdata),
    .tmo_q     (tmo_q),
    .data_q    (data_q)
);

// File: tb/tb_eeprom_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_eeprom_cmd_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 64;
    localparam int OFS_W      = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr = 1'b0;
    logic [OFS_W-1:0] reg_addr = '0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic             be_req, be_write;
    logic [12:0]      be_addr;
    logic [7:0]       be_wdata;
    logic             be_ack = 1'b0;
    logic [7:0]       be_rdata = '0;

    eeprom_cmd_ctrl #(.TMO_LIMIT(LIMIT), .OFS_W(OFS_W)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .be_req(be_req),
        .be_write(be_write), .be_addr(be_addr), .be_wdata(be_wdata),
        .be_ack(be_ack), .be_rdata(be_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural back end
    bit         present = 1'b1;
    int         lat = 0;
    int         bcnt = 0;
    logic [7:0] mem [int];

    always @(negedge clk) begin
        if (!rst_n) begin
            be_ack = 1'b0; bcnt = 0;
        end else if (be_ack) begin
            be_ack = 1'b0; bcnt = 0;
        end else if (be_req && present) begin
            if (bcnt >= lat) begin
                be_ack = 1'b1;
                if (be_write) mem[int'(be_addr)] = be_wdata;
                else be_rdata = mem.exists(int'(be_addr)) ? mem[int'(be_addr)] : 8'hFF;
            end else bcnt++;
        end else bcnt = 0;
    end

    // cycle-level reference model
    bit         m_busy = 0, m_tmo = 0;
    logic [1:0] m_op = 0;
    logic [12:0] m_addr = 0;
    logic [7:0] m_data = 0;
    int         m_cnt = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 0; m_tmo <= 0; m_op <= 0; m_addr <= 0; m_data <= 0; m_cnt <= 0;
        end else if (m_busy) begin
            if (be_ack) begin
                m_busy <= 0; m_cnt <= 0;
                if (m_op != 2'b11) m_data <= be_rdata;
            end else if (m_cnt == LIMIT - 1) begin
                m_busy <= 0; m_tmo <= 1; m_cnt <= 0;
            end else m_cnt <= m_cnt + 1;
        end else if (reg_wr) begin
            if (reg_addr == 0) begin
                m_addr <= reg_wdata[12:0];
                m_op   <= reg_wdata[29:28];
                if (reg_wdata[17]) m_tmo <= 0;
                if (reg_wdata[31]) begin m_busy <= 1; m_tmo <= 0; m_cnt <= 0; end
            end else if (reg_addr == 4) m_data <= reg_wdata[7:0];
        end
    end

    function automatic logic [31:0] model_rd(input logic [OFS_W-1:0] ofs);
        logic [31:0] w = '0;
        if (ofs == 0) begin
            w[31] = m_busy; w[29:28] = m_op; w[17] = m_tmo; w[12:0] = m_addr;
        end else if (ofs == 4) w[7:0] = m_data;
        return w;
    endfunction

    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            check(be_req == m_busy, "R3 be_req vs model", 32'(be_req), 32'(m_busy));
            if (m_busy) begin
                check(be_addr == m_addr, "R3 be_addr vs model", 32'(be_addr), 32'(m_addr));
                check(be_write == (m_op == 2'b11), "R3 be_write vs model", 32'(be_write), 32'(m_op == 2'b11));
                check(be_wdata == m_data, "R5 be_wdata vs model", 32'(be_wdata), 32'(m_data));
            end
            check(reg_rdata == model_rd(reg_addr), "R2 reg_rdata vs model", reg_rdata, model_rd(reg_addr));
        end
    end

    task automatic reg_write(input logic [OFS_W-1:0] ofs, input logic [31:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = ofs; reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    endtask

    task automatic reg_read(input logic [OFS_W-1:0] ofs, output logic [31:0] val);
        @(negedge clk);
        reg_addr = ofs;
        #1;
        val = reg_rdata;
    endtask

    task automatic wait_done(output int cycles);
        logic [31:0] v;
        cycles = 0;
        do begin
            reg_read(0, v);
            cycles++;
        end while (v[31] && cycles < 1000);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        int cyc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(0, v); check(v == 0, "R1 command word after reset", v, 0);
        reg_read(4, v); check(v == 0, "R1 data after reset", v, 0);
        check(be_req == 0, "R1 no request after reset", 32'(be_req), 0);

        // R5 write byte
        present = 1; lat = 3;
        reg_write(4, 32'h0000_00A5);
        reg_write(0, 32'hB000_0123);
        wait_done(cyc);
        reg_read(0, v); check(v == 32'h3000_0123, "R4 write completes, tmo clear", v, 32'h3000_0123);
        reg_read(4, v); check(v == 32'h0000_00A5, "R5 data unchanged by write", v, 32'hA5);
        check(mem[32'h123] == 8'hA5, "R5 byte reached back end", 32'(mem[32'h123]), 32'hA5);

        // R4 read back
        reg_write(4, 32'h0000_0000);
        reg_write(0, 32'h8000_0123);
        wait_done(cyc);
        reg_read(4, v); check(v == 32'h0000_00A5, "R4 read latches byte", v, 32'hA5);
        reg_read(0, v); check(v == 32'h0000_0123, "R2 command readback", v, 32'h123);

        // R2 address range ends
        lat = 0;
        reg_write(4, 32'h0000_003C); reg_write(0, 32'hB000_1FFF); wait_done(cyc);
        reg_write(4, 32'h0000_00C3); reg_write(0, 32'hB000_0000); wait_done(cyc);
        reg_write(0, 32'h8000_1FFF); wait_done(cyc);
        reg_read(4, v); check(v == 32'h3C, "R2 top address read", v, 32'h3C);
        reg_write(0, 32'h8000_0000); wait_done(cyc);
        reg_read(4, v); check(v == 32'hC3, "R2 address zero read", v, 32'hC3);

        // R2 opcode 01 is a read
        reg_write(0, 32'h9000_1FFF); wait_done(cyc);
        reg_read(4, v); check(v == 32'h3C, "R2 opcode 01 reads", v, 32'h3C);
        check(mem[32'h1FFF] == 8'h3C, "R2 opcode 01 leaves memory", 32'(mem[32'h1FFF]), 32'h3C);
        reg_read(2, v); check(v == 0, "R2 unmapped offset", v, 0);

        // R8 writes ignored while busy
        lat = 10;
        reg_write(0, 32'h8000_1FFF);
        reg_write(0, 32'hB000_0055);
        reg_write(4, 32'h0000_0077);
        wait_done(cyc);
        reg_read(0, v); check(v == 32'h0000_1FFF, "R8 command kept while busy", v, 32'h1FFF);
        reg_read(4, v); check(v == 32'h3C, "R8 data write dropped while busy", v, 32'h3C);
        check(!mem.exists(32'h55), "R8 no write issued", 32'(mem.exists(32'h55)), 0);

        // R6 R9 timeout on absent device
        present = 0;
        reg_write(0, 32'h8000_0000);
        wait_done(cyc);
        check(cyc == LIMIT, "R6 timeout length", cyc, LIMIT);
        reg_read(0, v); check(v == 32'h0002_0000, "R9 probe absent sets tmo", v, 32'h0002_0000);

        // R7 clear by bit 17
        reg_write(0, 32'h0002_0000);
        reg_read(0, v); check(v == 0, "R7 bit17 write clears tmo", v, 0);

        // R7 start clears
        reg_write(0, 32'h8000_0000); wait_done(cyc);
        present = 1; lat = 3;
        reg_write(0, 32'h8000_0000);
        reg_read(0, v); check(v == 32'h8000_0000, "R7 start clears tmo", v, 32'h8000_0000);
        wait_done(cyc);

        // R9 probe present
        reg_write(0, 32'h8000_0000); wait_done(cyc);
        reg_read(0, v); check(v == 0, "R9 probe present tmo clear", v, 0);
        reg_read(4, v); check(v == 32'hC3, "R9 probe reads byte 0", v, 32'hC3);

        // R6 ack on last allowed cycle, then one too late
        lat = LIMIT - 1;
        reg_write(0, 32'h8000_1FFF); wait_done(cyc);
        reg_read(0, v); check(v == 32'h0000_1FFF, "R6 last-cycle ack succeeds", v, 32'h1FFF);
        lat = LIMIT;
        reg_write(0, 32'h8000_1FFF); wait_done(cyc);
        reg_read(0, v); check(v == 32'h0002_1FFF, "R6 late ack times out", v, 32'h0002_1FFF);

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end
endmodule